// File: doc/BRIEF.md
# SPI Port Controller with Completion and Collision Flags

This block is a byte-wide SPI port that sits behind a small register interface. Software programs a control register (interrupt enable, master/slave role, clock polarity, clock phase, rate code), reads a status register with two sticky flags, and uses a data register. A write to the data register sends a byte, and a read of it returns the last byte received.

As master, the block divides the system clock down to SCK. The divisor depends on a two-bit rate code and on a core-mode input that selects 6-clock or 12-clock timing. It drives SS low for the whole byte and shifts eight bits full duplex, most significant bit first. As slave, it synchronises the external SCK, SS and MOSI, takes its bit timing from them, and drives MISO.

At the end of every byte, the received value is latched and a completion flag is raised, which can request an interrupt. A data write made while a byte is in flight is dropped and recorded in a sticky collision flag.

Top module: `spi_port_ctrl`

## Requirements
- R1: In master mode the SCK period is the system clock period times the divisor selected by control bits [1:0]. The divisors are 2, 8, 32, 64 for codes 0..3 when `clk6_mode` is 1, and 4, 16, 64, 128 when it is 0. Each SCK half period is half the divisor.
- R2: In slave mode (control bit 4 = 0) the rate code and `clk6_mode` have no effect. A slave byte completes identically under any rate code.
- R3: Control bit 2 selects the phase. With 0, data is sampled on the leading SCK edge and changed on the trailing edge. With 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: A transfer moves exactly eight bits, most significant bit first, out on the transmit line and in on the receive line at the same time.
- R5: Status bit 7 (completion) is set when a byte finishes. It stays set until software writes the status register (address 1) with bit 7 = 1.
- R6: `irq` is 1 exactly when the completion flag, control bit 7 and `port_irq_en` are all 1.
- R7: Status bit 6 (collision) is set by a write to the data register (address 2) while a byte is in flight. It stays set until software writes the status register with bit 6 = 1.
- R8: After reset the control, status and receive registers read 0, `sck_o` is low and `ss_n_o` is high. Status bits 5..0 always read 0.
- R9: Control bit 3 sets the SCK idle level: low when 0, high when 1.
- R10: A colliding data write is discarded. The byte in flight is shifted out unchanged.
- R11: In master mode, `ss_n_o` is low for all sixteen SCK edges of a byte and is high afterwards. In slave mode, bits are taken only while `ss_n_i` is low.
- R12: The received byte appears at address 2 in the same cycle that the completion flag becomes set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk6_mode | input | 1 | 1 = 6-clock core timing, 0 = 12-clock |
| port_irq_en | input | 1 | Port-level interrupt enable |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Master SCK |
| mosi_o | output | 1 | Master data out |
| ss_n_o | output | 1 | Master slave-select, active low |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave SCK from the external master |
| mosi_i | input | 1 | Slave data in |
| ss_n_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave data out |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a seven-bit half-period counter. The counter is wide enough for the largest half period (64 cycles in 12-clock mode, code 3), so the bench can measure every entry of both divisor tables.

With two stages, slave-side delay is three cycles. This leaves a ten-cycle external half period ample margin, so all four polarity/phase modes can be exercised in both roles. The same margin allows a collision write to land in the middle of a byte.

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HCNT_W      = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk6_mode,
  input  logic       port_irq_en,
  input  logic [1:0] reg_sel,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       ss_n_o,
  input  logic       miso_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       ss_n_i,
  output logic       miso_o
);
  localparam int BYTE_W = 8;
  localparam int NB_W   = $clog2(BYTE_W);
  localparam int EDGE_W = $clog2(2 * BYTE_W + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W);
  localparam logic [NB_W-1:0]   LAST_BIT  = NB_W'(BYTE_W - 1);
  localparam logic [7:0]        CTRL_MASK = 8'h9F;

  logic [7:0] ctrl_q;
  logic [BYTE_W-1:0] shreg, rx_buf;
  logic samp, done_q, wcol_q;
  logic [NB_W-1:0] nbits;

  wire wr_ctrl = reg_we && (reg_sel == 2'd0);
  wire wr_stat = reg_we && (reg_sel == 2'd1);
  wire wr_data = reg_we && (reg_sel == 2'd2);

  wire       spie = ctrl_q[7];
  wire       mstr = ctrl_q[4];
  wire       cpol = ctrl_q[3];
  wire       cpha = ctrl_q[2];
  wire [1:0] rate = ctrl_q[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;

  // master clock generator
  logic [2:0] base_sh, sh;
  logic [HCNT_W-1:0] hcnt, half_m1;
  logic [EDGE_W-1:0] edge_n;
  logic m_busy, m_ss_n, sck_act;

  always_comb begin
    case (rate)
      2'd0:    base_sh = 3'd0;
      2'd1:    base_sh = 3'd2;
      2'd2:    base_sh = 3'd4;
      default: base_sh = 3'd5;
    endcase
    sh      = base_sh + {2'b00, ~clk6_mode};
    half_m1 = (HCNT_W'(1) << sh) - HCNT_W'(1);
  end

  wire start  = wr_data && mstr && !m_busy;
  wire tick   = m_busy && (hcnt == half_m1);
  wire m_lead = tick && (edge_n != LAST_EDGE) && !edge_n[0];
  wire m_trl  = tick && (edge_n != LAST_EDGE) &&  edge_n[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_busy  <= 1'b0;
      m_ss_n  <= 1'b1;
      sck_act <= 1'b0;
      edge_n  <= '0;
      hcnt    <= '0;
    end else if (m_busy) begin
      if (tick) begin
        hcnt <= '0;
        if (edge_n == LAST_EDGE) begin
          m_busy <= 1'b0;
          m_ss_n <= 1'b1;
        end else begin
          sck_act <= ~sck_act;
          edge_n  <= edge_n + EDGE_W'(1);
        end
      end else begin
        hcnt <= hcnt + HCNT_W'(1);
      end
    end else if (start) begin
      m_busy  <= 1'b1;
      m_ss_n  <= 1'b0;
      sck_act <= 1'b0;
      edge_n  <= '0;
      hcnt    <= '0;
    end

  assign sck_o  = cpol ^ sck_act;
  assign ss_n_o = m_ss_n;

  // slave input synchronisers
  logic [SYNC_STAGES-1:0] sck_sync, ss_sync, mosi_sync;
  logic sck_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sync  <= '0;
      ss_sync   <= '1;
      mosi_sync <= '0;
      sck_p     <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      ss_sync   <= {ss_sync[SYNC_STAGES-2:0], ss_n_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sck_p     <= sck_sync[SYNC_STAGES-1];
    end

  wire sck_s  = sck_sync[SYNC_STAGES-1];
  wire ss_act = !ss_sync[SYNC_STAGES-1];
  wire s_chg  = !mstr && ss_act && (sck_s != sck_p);
  wire s_lead = s_chg && (sck_s != cpol);
  wire s_trl  = s_chg && (sck_s == cpol);

  // shared shift datapath
  wire busy     = mstr ? m_busy : ss_act;
  wire lead_ev  = mstr ? m_lead : s_lead;
  wire trl_ev   = mstr ? m_trl  : s_trl;
  wire din      = mstr ? miso_i : mosi_sync[SYNC_STAGES-1];
  wire sample_ev = cpha ? trl_ev : lead_ev;
  wire shift_ev  = cpha ? lead_ev : trl_ev;
  wire byte_end  = sample_ev && (nbits == LAST_BIT);
  wire load      = wr_data && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      samp   <= 1'b0;
      nbits  <= '0;
      rx_buf <= '0;
    end else if (load) begin
      shreg <= reg_wdata;
      nbits <= '0;
    end else if (!mstr && !ss_act) begin
      nbits <= '0;
    end else begin
      if (sample_ev) begin
        samp  <= din;
        nbits <= nbits + NB_W'(1);
        if (byte_end) rx_buf <= {shreg[BYTE_W-2:0], din};
      end
      if (shift_ev && (nbits != '0))
        shreg <= {shreg[BYTE_W-2:0], samp};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      if (byte_end)                    done_q <= 1'b1;
      else if (wr_stat && reg_wdata[7]) done_q <= 1'b0;
      if (wr_data && busy)             wcol_q <= 1'b1;
      else if (wr_stat && reg_wdata[6]) wcol_q <= 1'b0;
    end

  assign mosi_o = shreg[BYTE_W-1];
  assign miso_o = shreg[BYTE_W-1];
  assign irq    = done_q && spie && port_irq_en;

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = ctrl_q;
      2'd1:    reg_rdata = {done_q, wcol_q, 6'b0};
      2'd2:    reg_rdata = rx_buf;
      default: reg_rdata = '0;
    endcase

  AST_SS_HELD_WHILE_SCK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr && (sck_o != cpol)) |-> !ss_n_o); // R11
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr && ss_n_o) |-> (sck_o == cpol)); // R9
  AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol_q); // R7
  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_q && !(wr_stat && reg_wdata[6])) |=> wcol_q); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_stat && reg_wdata[7])) |=> done_q); // R5
  AST_COLLIDE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr && m_busy && wr_data && !shift_ev) |=> (shreg == $past(shreg))); // R10
endmodule

// File: tb/spi_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_port_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk6_mode = 1'b1, port_irq_en = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, sck_o, mosi_o, ss_n_o, miso_o;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  longint cyc = 0;

  spi_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .clk6_mode(clk6_mode), .port_irq_en(port_irq_en),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .ss_n_o(ss_n_o), .miso_i(miso_i),
    .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  // scoreboard: driver pushes bytes the master should send, bench slave pops them
  logic [7:0] exp_q[$];
  logic [7:0] slave_byte, s_tx, s_rx;
  int s_cnt = 0, s_edges = 0;
  bit b_cpol = 1'b0, b_cpha = 1'b0, s_lead;

  always @(negedge ss_n_o) begin
    s_tx = slave_byte; miso_i = s_tx[7];
    s_cnt = 0; s_edges = 0; s_rx = 8'h00;
  end

  always @(sck_o) if (ss_n_o === 1'b0) begin
    s_edges++;
    s_lead = (sck_o != b_cpol);
    if (s_lead != b_cpha) begin
      s_rx = {s_rx[6:0], mosi_o};
      s_cnt++;
      if (s_cnt == 8) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte on mosi", s_rx, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(s_rx == e, "R4 R3 R10 byte seen on mosi", s_rx, e);
        end
      end
    end else if (s_cnt != 0 && s_cnt < 8) begin
      s_tx = s_tx << 1; miso_i = s_tx[7];
    end
  end

  // SCK change timing capture
  logic sck_prev = 1'b0;
  int n_chg = 0;
  longint t_chg0 = 0, t_chg1 = 0;
  always @(negedge clk) begin
    if (ss_n_o === 1'b0 && sck_o !== sck_prev) begin
      if (n_chg == 0) t_chg0 = cyc;
      else if (n_chg == 1) t_chg1 = cyc;
      n_chg++;
    end
    sck_prev = sck_o;
  end

  function automatic int exp_half(input bit m6, input logic [1:0] r);
    int div6[4]  = '{2, 8, 32, 64};
    int div12[4] = '{4, 16, 64, 128};
    return (m6 ? div6[r] : div12[r]) / 2;
  endfunction

  task automatic mxfer(input bit cpol, input bit cpha, input logic [1:0] rate, input bit m6,
                       input logic [7:0] tx, input logic [7:0] sb, input bit collide, input bit ien);
    logic [7:0] st, dat, old;
    bit seen = 1'b0, early_bad = 1'b0;
    clk6_mode = m6; b_cpol = cpol; b_cpha = cpha; slave_byte = sb;
    reg_write(2'd0, {ien, 2'b00, 1'b1, cpol, cpha, rate});
    @(negedge clk);
    chk(sck_o == cpol, "R9 idle level", sck_o, cpol);
    reg_read(2'd2, old);
    exp_q.push_back(tx);
    n_chg = 0;
    reg_write(2'd2, tx);
    for (int it = 0; it < 4000 && !seen; it++) begin
      if (collide && it == 40) reg_write(2'd2, ~tx);
      else @(negedge clk);
      reg_read(2'd1, st);
      reg_read(2'd2, dat);
      if (st[7]) seen = 1'b1;
      else if (dat != old) early_bad = 1'b1;
    end
    chk(seen, "R5 completion flag set", st, 8'h80);
    chk(!early_bad, "R12 rx unchanged before flag", early_bad, 0);
    chk(dat == sb, "R12 R4 R3 rx at flag", dat, sb);
    chk(irq == (ien & port_irq_en), "R6 irq", irq, ien & port_irq_en);
    chk(t_chg1 - t_chg0 == exp_half(m6, rate), "R1 half period", t_chg1 - t_chg0, exp_half(m6, rate));
    for (int k = 0; k < 300 && ss_n_o !== 1'b1; k++) @(negedge clk);
    chk(ss_n_o == 1'b1, "R11 ss released", ss_n_o, 1);
    chk(s_edges == 16, "R11 edges while ss low", s_edges, 16);
    chk(sck_o == cpol, "R9 idle after byte", sck_o, cpol);
    reg_read(2'd1, st);
    chk(st == {1'b1, collide, 6'b0}, "R7 R8 status", st, {1'b1, collide, 6'b0});
    repeat (3) @(negedge clk);
    reg_read(2'd1, st);
    chk(st[7], "R5 flag sticky", st, 8'h80);
    reg_write(2'd1, 8'h80);
    reg_read(2'd1, st);
    chk(st == {1'b0, collide, 6'b0}, "R5 R7 clear completion only", st, {1'b0, collide, 6'b0});
    if (collide) begin
      reg_write(2'd1, 8'h40);
      reg_read(2'd1, st);
      chk(st == 8'h00, "R7 clear collision", st, 0);
    end
  endtask

  task automatic sxfer(input bit cpol, input bit cpha, input logic [1:0] rate, input bit m6,
                       input logic [7:0] dut_tx, input logic [7:0] host_tx);
    logic [7:0] got, st, dat;
    clk6_mode = m6;
    sck_i = cpol; ss_n_i = 1'b1;
    reg_write(2'd0, {3'b000, 1'b0, cpol, cpha, rate});
    repeat (4) @(negedge clk);
    reg_write(2'd2, dut_tx);
    mosi_i = host_tx[7];
    ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        got[7-i] = miso_o;
        sck_i = ~cpol; repeat (10) @(negedge clk);
        sck_i = cpol; if (i < 7) mosi_i = host_tx[6-i];
        repeat (10) @(negedge clk);
      end else begin
        sck_i = ~cpol; mosi_i = host_tx[7-i];
        repeat (10) @(negedge clk);
        got[7-i] = miso_o;
        sck_i = cpol; repeat (10) @(negedge clk);
      end
    end
    repeat (5) @(negedge clk);
    reg_read(2'd1, st);
    reg_read(2'd2, dat);
    chk(st == 8'h80, "R2 R5 slave completion", st, 8'h80);
    chk(dat == host_tx, "R2 R3 R4 slave rx", dat, host_tx);
    chk(got == dut_tx, "R2 R3 R4 slave tx on miso", got, dut_tx);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_write(2'd1, 8'h80);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(2'd0, v); chk(v == 8'h00, "R8 control reset", v, 0);
    reg_read(2'd1, v); chk(v == 8'h00, "R8 status reset", v, 0);
    reg_read(2'd2, v); chk(v == 8'h00, "R8 data reset", v, 0);
    chk(sck_o == 1'b0 && ss_n_o == 1'b1 && irq == 1'b0, "R8 pins reset", {sck_o, ss_n_o, irq}, 3'b010);

    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 4; r++)
        mxfer(r[0], r[1], 2'(r), m[0], 8'hA5 ^ 8'(r * 17 + m), 8'h3C ^ 8'(r * 5 + m * 64), 1'b0, 1'b1);

    port_irq_en = 1'b0;
    mxfer(1'b1, 1'b0, 2'd0, 1'b1, 8'h81, 8'h7E, 1'b0, 1'b1);
    port_irq_en = 1'b1;
    mxfer(1'b0, 1'b1, 2'd0, 1'b1, 8'h18, 8'hE7, 1'b0, 1'b0);

    mxfer(1'b0, 1'b0, 2'd1, 1'b0, 8'hC3, 8'h5A, 1'b1, 1'b1);
    mxfer(1'b1, 1'b1, 2'd1, 1'b0, 8'h0F, 8'hF0, 1'b1, 1'b1);

    sxfer(1'b0, 1'b0, 2'd0, 1'b1, 8'h96, 8'h4B);
    sxfer(1'b0, 1'b0, 2'd3, 1'b0, 8'h96, 8'h4B);
    sxfer(1'b1, 1'b1, 2'd3, 1'b1, 8'h2D, 8'hD2);
    sxfer(1'b0, 1'b1, 2'd1, 1'b0, 8'hE1, 8'h1E);
    sxfer(1'b1, 1'b0, 2'd2, 1'b1, 8'h55, 8'hAA);

    // SCK activity with SS high must take no bits
    for (int i = 0; i < 8; i++) begin
      mosi_i = i[0];
      sck_i = 1'b1; repeat (10) @(negedge clk);
      sck_i = 1'b0; repeat (10) @(negedge clk);
    end
    reg_read(2'd1, v); chk(v == 8'h00, "R11 no completion with ss high", v, 0);
    reg_read(2'd2, v); chk(v == 8'hAA, "R11 rx kept with ss high", v, 8'hAA);

    chk(exp_q.size() == 0, "R4 all queued bytes seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule